// File: doc/BRIEF.md
# Sequential-Trigger Logic Capture Engine

This block watches a parallel group of digital channels and records them into an on-chip sample buffer once an ordered chain of trigger patterns has been seen. Each trigger stage compares the sampled channels against a programmed value under a per-channel care mask. A stage may also demand that its pattern stay true for a run of consecutive samples before the chain moves on to the next stage. When the last stage is satisfied, that sample and the ones that follow are stored. A store filter, made of its own mask and value, drops samples that do not match it.

Samples come from one of two sources. In timing mode, every cycle in which the internal sample strobe is high yields one sample. In state mode, an external sample clock is synchronised into the system clock domain, and each rising edge of it yields one sample. The engine is armed by a pulse. It reports whether it is hunting for the trigger, capturing, full or done, together with the number of stored samples. After the run, the buffer is read back through a synchronous address/data port.

Top module: `la_capture_engine`

## Requirements
- R1: After a synchronous active-low reset, `armed`, `triggered`, `full` and `done` are 0 and `count` is 0.
- R2: An `arm` pulse while idle clears `count` and `done` and starts the hunt at stage 0. `armed` is 1 after the next clock edge.
- R3: Stage g uses `trig_mask[g*8+:8]` and `trig_value[g*8+:8]`. A sample matches when every channel whose mask bit is 1 equals its value bit. Stages are evaluated strictly in order 0,1,2,3, and one sample can complete at most one stage.
- R4: With a hold value H in `trig_hold[g*16+:16]`, stage g completes on the (H+1)-th consecutive matching sample. Any non-matching sample restarts the run, and the chain stays at that stage. H=0 means the first match completes the stage.
- R5: The sample that completes the last stage is the first candidate for storage, and `triggered` goes to 1 from that point on.
- R6: While capturing, a sample is stored only if it matches `qual_value` under `qual_mask` (mask bit 1 = compared). A filtered sample is not stored and not counted.
- R7: Once `count` reaches DEPTH (16), `full` is 1 and later samples are not stored. One cycle later `done` is 1 and `armed` and `triggered` are 0.
- R8: When `state_mode` is 0, one sample is taken per cycle with `smp_tick` high, and `ext_sclk` has no effect.
- R9: When `state_mode` is 1, one sample is taken per rising edge of `ext_sclk`, seen after a two-flop synchroniser, and `smp_tick` has no effect.
- R10: The value on `rd_data` is the sample stored at address `rd_addr` one cycle earlier. Addresses run from 0 in store order.
- R11: An `arm` pulse while the engine is hunting or capturing is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| state_mode | input | 1 | 1 = external-clock sampling, 0 = internal-strobe sampling |
| ext_sclk | input | 1 | External sample clock (asynchronous) |
| smp_tick | input | 1 | Internal sample strobe |
| ch_in | input | 8 | Monitored channels |
| arm | input | 1 | Start pulse |
| trig_mask | input | 32 | Care masks, stage g in bits g*8+:8 |
| trig_value | input | 32 | Pattern values, stage g in bits g*8+:8 |
| trig_hold | input | 64 | Hold counts, stage g in bits g*16+:16 |
| qual_mask | input | 8 | Store-filter care mask |
| qual_value | input | 8 | Store-filter value |
| rd_addr | input | 4 | Buffer read address |
| rd_data | output | 8 | Buffer read data, one cycle latency |
| armed | output | 1 | Hunting or capturing |
| triggered | output | 1 | Capturing after trigger |
| full | output | 1 | Buffer holds DEPTH samples |
| done | output | 1 | Last run filled the buffer |
| count | output | 5 | Number of stored samples |

## Verification
Two functions act on the same cycle: completing the final trigger stage and deciding whether to store that very sample. The bench makes the triggering sample both pass and fail the store filter. It then checks that the count and the read-back contents include the triggering sample only when it passes. A second overlap is the buffer reaching full while more samples keep arriving. Extra samples are driven after the last slot is written, and the bench confirms that the count stays at DEPTH and that `done` follows one cycle later.

// File: rtl/la_pkg.sv
// Shared types and helpers for the logic capture engine.
package la_pkg;

    // Engine phase: waiting for arm, hunting for trigger, storing samples.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HUNT = 2'd1,
        PH_CAPT = 2'd2
    } la_phase_e;

    // Index width with a floor of one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/la_sample_src.sv
// Sample source: turns either the internal strobe or a synchronised
// rising edge of the external sample clock into a one-cycle sample
// valid with the channel word captured alongside.
// Assumes ext_sclk is asynchronous and slower than half the system clock,
// and that channels are stable around the external edge.
module la_sample_src #(
    parameter int NCH         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           state_mode,
    input  logic           ext_sclk,
    input  logic           smp_tick,
    input  logic [NCH-1:0] ch_in,
    output logic           smp_valid,
    output logic [NCH-1:0] smp_data
);

    logic [SYNC_STAGES:0] sync_q;
    logic                 ext_rise;
    logic                 take;

    // Synchroniser chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-1:0], ext_sclk};
        end
    end

    assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
    assign take     = state_mode ? ext_rise : smp_tick;

    // Register the sample enable and the channel word it qualifies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid <= 1'b0;
            smp_data  <= '0;
        end else begin
            smp_valid <= take;
            if (take) begin
                smp_data <= ch_in;
            end
        end
    end

    // R9: an external edge yields a single isolated sample.
    p_single_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_mode && smp_valid && !smp_tick) |=> !smp_valid);

endmodule

// File: rtl/la_trig_seq.sv
// Trigger sequencer and run control. Walks the ordered pattern stages,
// counts hold runs, flags the completing sample of the last stage and
// holds the idle/hunt/capture phase until the buffer reports full.
// Assumes stage configuration is static while armed.
module la_trig_seq
    import la_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int NSTG = 4,
    parameter int HW   = 16,
    localparam int SW  = idx_w(NSTG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm,
    input  logic                smp_valid,
    input  logic [NCH-1:0]      smp_data,
    input  logic [NSTG*NCH-1:0] stg_mask,
    input  logic [NSTG*NCH-1:0] stg_value,
    input  logic [NSTG*HW-1:0]  stg_hold,
    input  logic                buf_full,
    output logic                clear,
    output logic                fire,
    output logic                capt_en,
    output logic                armed,
    output logic                capturing,
    output logic                done
);

    la_phase_e       phase;
    logic [SW-1:0]   stg;
    logic [HW-1:0]   hcnt;
    logic [NSTG-1:0] hit_v;
    logic [HW-1:0]   hold_a [NSTG];
    logic            cur_hit;
    logic [HW-1:0]   cur_hold;
    logic            last_stg;
    logic            stage_done;

    // Per-stage masked pattern compare and hold lookup.
    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        assign hit_v[g]  = (((smp_data ^ stg_value[g*NCH +: NCH])
                             & stg_mask[g*NCH +: NCH]) == '0);
        assign hold_a[g] = stg_hold[g*HW +: HW];
    end

    assign cur_hit    = hit_v[stg];
    assign cur_hold   = hold_a[stg];
    assign last_stg   = (stg == SW'(NSTG - 1));
    assign stage_done = (phase == PH_HUNT) && smp_valid && cur_hit
                        && (hcnt == cur_hold);
    assign fire       = stage_done && last_stg;
    assign capt_en    = smp_valid && ((phase == PH_CAPT) || fire);
    assign clear      = arm && (phase == PH_IDLE);
    assign armed      = (phase != PH_IDLE);
    assign capturing  = (phase == PH_CAPT);

    // Phase, stage index and hold-run counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            stg   <= '0;
            hcnt  <= '0;
            done  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (arm) begin
                        phase <= PH_HUNT;
                        stg   <= '0;
                        hcnt  <= '0;
                        done  <= 1'b0;
                    end
                end
                PH_HUNT: begin
                    if (smp_valid) begin
                        if (!cur_hit) begin
                            hcnt <= '0;
                        end else if (hcnt == cur_hold) begin
                            hcnt <= '0;
                            if (last_stg) begin
                                phase <= PH_CAPT;
                            end else begin
                                stg <= stg + SW'(1);
                            end
                        end else begin
                            hcnt <= hcnt + HW'(1);
                        end
                    end
                end
                PH_CAPT: begin
                    if (buf_full) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R4: the run counter never passes the stage's hold value.
    p_hold_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HUNT) |-> (hcnt <= cur_hold));

    // R4: a miss restarts the run at the same stage.
    p_miss_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HUNT && smp_valid && !cur_hit) |=> (hcnt == '0 && $stable(stg)));

    // R3: without a sample, the chain does not move.
    p_no_sample_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HUNT && !smp_valid) |=> ($stable(stg) && $stable(hcnt)));

    // R7: a full buffer ends the run with done set.
    p_full_ends_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CAPT && buf_full) |=> (phase == PH_IDLE && done));

endmodule

// File: rtl/la_cap_buf.sv
// Capture buffer: appends qualified samples until DEPTH entries are held,
// keeps the fill count and serves a registered read port.
// Assumes the read port is used while no run is in progress.
module la_cap_buf
    import la_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int DEPTH = 16,
    localparam int AW   = idx_w(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           wr_req,
    input  logic [NCH-1:0] wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [NCH-1:0] rd_data,
    output logic [CW-1:0]  count,
    output logic           full
);

    logic [NCH-1:0] mem [DEPTH];
    logic           wr_go;

    assign full  = (count == CW'(DEPTH));
    assign wr_go = wr_req && !full;

    // Fill counter: cleared on arm, bumped on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (wr_go) begin
            count <= count + CW'(1);
        end
    end

    // Sample storage at the current fill position.
    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem[count[AW-1:0]] <= wr_data;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= mem[rd_addr];
        end
    end

    // R7: the count never exceeds the buffer depth.
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R7: a full buffer accepts nothing more.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clear) |=> $stable(count));

endmodule

// File: rtl/la_capture_engine.sv
// Top of the logic capture engine: sample source, trigger sequencer,
// store filter and capture buffer.
// Assumes configuration ports are static while armed.
module la_capture_engine
    import la_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int NSTG        = 4,
    parameter int HW          = 16,
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = idx_w(DEPTH),
    localparam int CW         = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                state_mode,
    input  logic                ext_sclk,
    input  logic                smp_tick,
    input  logic [NCH-1:0]      ch_in,
    input  logic                arm,
    input  logic [NSTG*NCH-1:0] trig_mask,
    input  logic [NSTG*NCH-1:0] trig_value,
    input  logic [NSTG*HW-1:0]  trig_hold,
    input  logic [NCH-1:0]      qual_mask,
    input  logic [NCH-1:0]      qual_value,
    input  logic [AW-1:0]       rd_addr,
    output logic [NCH-1:0]      rd_data,
    output logic                armed,
    output logic                triggered,
    output logic                full,
    output logic                done,
    output logic [CW-1:0]       count
);

    logic           smp_valid;
    logic [NCH-1:0] smp_data;
    logic           clear;
    logic           fire;
    logic           capt_en;
    logic           qual_hit;
    logic           wr_req;

    la_sample_src #(
        .NCH         (NCH),
        .SYNC_STAGES (SYNC_STAGES)
    ) i_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_mode (state_mode),
        .ext_sclk   (ext_sclk),
        .smp_tick   (smp_tick),
        .ch_in      (ch_in),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data)
    );

    la_trig_seq #(
        .NCH  (NCH),
        .NSTG (NSTG),
        .HW   (HW)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .stg_mask  (trig_mask),
        .stg_value (trig_value),
        .stg_hold  (trig_hold),
        .buf_full  (full),
        .clear     (clear),
        .fire      (fire),
        .capt_en   (capt_en),
        .armed     (armed),
        .capturing (triggered),
        .done      (done)
    );

    // Store filter applied to every capture candidate.
    assign qual_hit = (((smp_data ^ qual_value) & qual_mask) == '0);
    assign wr_req   = capt_en && qual_hit;

    la_cap_buf #(
        .NCH   (NCH),
        .DEPTH (DEPTH)
    ) i_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .wr_req  (wr_req),
        .wr_data (smp_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .count   (count),
        .full    (full)
    );

    // R5: a qualifying triggering sample is stored in the same cycle.
    p_trigger_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && qual_hit && !full) |=> (count == $past(count) + CW'(1)));

    // R6: a filtered sample never changes the count.
    p_filtered_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !qual_hit && !clear) |=> $stable(count));

endmodule

// File: tb/test_la_capture_engine.sv
// Scoreboard bench: the driver model pushes expected stored samples into a
// queue; the read-back monitor pops and compares them.
module test_la_capture_engine;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        state_mode = 1'b0;
    logic        ext_sclk = 1'b0;
    logic        smp_tick = 1'b0;
    logic [7:0]  ch_in = '0;
    logic        arm = 1'b0;
    logic [31:0] trig_mask = '0;
    logic [31:0] trig_value = '0;
    logic [63:0] trig_hold = '0;
    logic [7:0]  qual_mask = '0;
    logic [7:0]  qual_value = '0;
    logic [3:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        armed, triggered, full, done;
    logic [4:0]  count;

    int checks = 0;
    int errors = 0;

    // model state
    int         m_phase = 0;
    int         m_st = 0;
    int         m_hc = 0;
    int         m_cnt = 0;
    int         m_done = 0;
    logic [7:0] m_mask [4];
    logic [7:0] m_val  [4];
    int         m_hold [4];
    logic [7:0] exp_q [$];

    la_capture_engine i_la_capture_engine (
        .clk(clk), .rst_n(rst_n), .state_mode(state_mode), .ext_sclk(ext_sclk),
        .smp_tick(smp_tick), .ch_in(ch_in), .arm(arm), .trig_mask(trig_mask),
        .trig_value(trig_value), .trig_hold(trig_hold), .qual_mask(qual_mask),
        .qual_value(qual_value), .rd_addr(rd_addr), .rd_data(rd_data),
        .armed(armed), .triggered(triggered), .full(full), .done(done), .count(count)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic apply_cfg();
        for (int g = 0; g < 4; g++) begin
            trig_mask[g*8 +: 8]   = m_mask[g];
            trig_value[g*8 +: 8]  = m_val[g];
            trig_hold[g*16 +: 16] = 16'(m_hold[g]);
        end
    endtask

    task automatic model_store(input logic [7:0] d);
        if (((d ^ qual_value) & qual_mask) == 8'h00) begin
            exp_q.push_back(d);
            m_cnt++;
            if (m_cnt == DEPTH) begin
                m_phase = 0;
                m_done  = 1;
            end
        end
    endtask

    task automatic model_step(input logic [7:0] d);
        if (m_phase == 1) begin
            if (((d ^ m_val[m_st]) & m_mask[m_st]) == 8'h00) begin
                if (m_hc == m_hold[m_st]) begin
                    m_hc = 0;
                    if (m_st == 3) begin
                        m_phase = 2;
                        model_store(d);
                    end else begin
                        m_st++;
                    end
                end else begin
                    m_hc++;
                end
            end else begin
                m_hc = 0;
            end
        end else if (m_phase == 2) begin
            model_store(d);
        end
    endtask

    task automatic observe(input string tag);
        check({tag, " triggered"}, int'(triggered), int'(m_phase == 2));
        check({tag, " armed"}, int'(armed), int'(m_phase != 0));
        check({tag, " done"}, int'(done), m_done);
        check({tag, " count"}, int'(count), m_cnt);
    endtask

    task automatic do_arm();
        @(negedge clk) arm = 1'b1;
        @(negedge clk) arm = 1'b0;
        if (m_phase == 0) begin
            m_phase = 1; m_st = 0; m_hc = 0; m_cnt = 0; m_done = 0;
            exp_q.delete();
        end
    endtask

    task automatic tick_raw(input logic [7:0] d);
        @(negedge clk) begin ch_in = d; smp_tick = 1'b1; end
        @(negedge clk) smp_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic ext_raw(input logic [7:0] d);
        @(negedge clk) begin ch_in = d; ext_sclk = 1'b1; end
        repeat (3) @(negedge clk);
        ext_sclk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic tick_sample(input logic [7:0] d, input string tag);
        tick_raw(d);
        model_step(d);
        observe(tag);
    endtask

    task automatic ext_sample(input logic [7:0] d, input string tag);
        ext_raw(d);
        model_step(d);
        observe(tag);
    endtask

    // monitor: read the buffer back and pop expected items
    task automatic readback(input string tag);
        int n;
        logic [7:0] e;
        n = exp_q.size();
        check({tag, " stored count"}, int'(count), n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) rd_addr = 4'(i);
            @(negedge clk);
            e = exp_q.pop_front();
            check({tag, " R10 read data"}, int'(rd_data), int'(e));
        end
    endtask

    // watchdog
    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 armed", int'(armed), 0);
        check("R1 triggered", int'(triggered), 0);
        check("R1 full", int'(full), 0);
        check("R1 done", int'(done), 0);
        check("R1 count", int'(count), 0);
        rst_n = 1'b1;

        // Test A: four ordered stages, timing mode
        m_mask[0] = 8'h01; m_val[0] = 8'h01; m_hold[0] = 0;
        m_mask[1] = 8'h06; m_val[1] = 8'h00; m_hold[1] = 0;
        m_mask[2] = 8'h08; m_val[2] = 8'h08; m_hold[2] = 3;
        m_mask[3] = 8'h00; m_val[3] = 8'h00; m_hold[3] = 0;
        apply_cfg();
        qual_mask = 8'h00; qual_value = 8'h00;
        do_arm();
        check("R2 armed after arm", int'(armed), 1);
        check("R2 count after arm", int'(count), 0);
        // R8: external clock edges ignored in timing mode
        for (int i = 0; i < 8; i++) ext_raw(8'h09);
        check("R8 ext ignored triggered", int'(triggered), 0);
        check("R8 ext ignored count", int'(count), 0);
        tick_sample(8'h00, "R3 stage0 miss");
        tick_sample(8'h01, "R3 stage0 hit");
        tick_sample(8'h07, "R3 stage1 miss");
        tick_sample(8'h01, "R3 stage1 hit");
        tick_sample(8'h08, "R4 hold run");
        tick_sample(8'h08, "R4 hold run");
        tick_sample(8'h00, "R4 hold broken");
        for (int i = 0; i < 4; i++) tick_sample(8'h08, "R4 hold run");
        tick_sample(8'h55, "R5 final stage");
        for (int i = 0; i < 20; i++) tick_sample(8'(8'h10 + i), "R7 capture to full");
        check("R7 full", int'(full), 1);
        check("R7 count at depth", int'(count), DEPTH);
        readback("A");

        // Test B: hold on stage 0, store filter, re-arm while armed
        m_mask[0] = 8'hF0; m_val[0] = 8'hA0; m_hold[0] = 1;
        for (int g = 1; g < 4; g++) begin m_mask[g] = 8'h00; m_val[g] = 8'h00; m_hold[g] = 0; end
        apply_cfg();
        qual_mask = 8'h80; qual_value = 8'h80;
        do_arm();
        check("R2 rearm clears count", int'(count), 0);
        check("R2 rearm clears done", int'(done), 0);
        tick_sample(8'hA3, "R4 first match");
        do_arm();
        observe("R11 arm ignored");
        tick_sample(8'hA5, "R4 second match");
        tick_sample(8'h81, "R3 stage1");
        tick_sample(8'h02, "R3 stage2");
        tick_sample(8'h03, "R6 trigger sample filtered");
        check("R6 filtered trigger not stored", int'(count), 0);
        lfsr = 8'h5B;
        for (int i = 0; i < 50; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            tick_sample(lfsr, "R6 filtered capture");
        end
        readback("B");

        // Test C: state mode, strobe ignored, trigger sample stored
        state_mode = 1'b1;
        m_mask[0] = 8'hFF; m_val[0] = 8'h3C; m_hold[0] = 2;
        for (int g = 1; g < 4; g++) begin m_mask[g] = 8'h00; m_val[g] = 8'h00; m_hold[g] = 0; end
        apply_cfg();
        qual_mask = 8'h00; qual_value = 8'h00;
        do_arm();
        for (int i = 0; i < 8; i++) tick_raw(8'h3C);
        check("R9 strobe ignored triggered", int'(triggered), 0);
        check("R9 strobe ignored count", int'(count), 0);
        ext_sample(8'h3C, "R9 edge sample");
        ext_sample(8'h3C, "R9 edge sample");
        ext_sample(8'h00, "R4 hold broken");
        for (int i = 0; i < 3; i++) ext_sample(8'h3C, "R9 hold run");
        ext_sample(8'h11, "R9 stage1");
        ext_sample(8'h22, "R9 stage2");
        ext_sample(8'h33, "R5 trigger sample stored");
        check("R5 trigger sample counted", int'(count), 1);
        for (int i = 0; i < 17; i++) ext_sample(8'(8'hC0 + i), "R9 capture");
        check("R7 done after full", int'(done), 1);
        readback("C");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule